// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures how often an external digital signal rises within a fixed time window. Firmware first writes a measurement mode and a gate-time code, then pulses a start command. The block clears its running count, opens a gate for a whole number of reference ticks, and counts rising edges of the input after a synchronizer. When the gate closes, the total is copied into a result register and a completion flag goes high. The flag stays high until firmware clears it or starts another measurement.

The reference tick is a one-cycle strobe at the reference rate, which defaults to 75 kHz. The four gate times are therefore 75, 300, 600 and 2400 ticks. An inhibit input models the low-power states in which the counter input is switched off. While inhibit is high the gate timer keeps running but no edges are added. If the count would pass its largest value, it stops at all ones and an overflow bit is set.

Top module: `freq_ctr`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `result` are all zero.
- R2: `cfg_mode` and `cfg_time` are captured only in a cycle with `cfg_we` high. A later start uses the captured values, and changing the two buses without `cfg_we` has no effect.
- R3: After an accepted start, `busy` stays high for 75, 300, 600 or 2400 reference ticks when the captured time code is 2'b00, 2'b01, 2'b10 or 2'b11, respectively.
- R4: At the end of the gate, `result` becomes the number of rising edges that `sig_in` made while the gate was open. Edges after the gate closes are not counted. `result` keeps its previous value until the next gate closes.
- R5: `done` rises in the cycle the gate closes. A `done_clr` pulse clears it. If a clear arrives in the same cycle as a gate close, the close wins and `done` stays set.
- R6: A start while `busy` is high restarts the gate from its full length, zeroes the running count and clears `done`.
- R7: Rising edges of `sig_in` that occur while `inhibit` is high are not counted.
- R8: If more edges arrive than the counter can hold, `result` is all ones and `overflow` is 1. Exactly the maximum count gives all ones with `overflow` at 0.
- R9: A start is accepted only when the captured mode code is 2'b00 (frequency measurement). With any other mode code, start leaves `busy` and `done` unchanged.
- R10: The gate advances only in cycles where `ref_tick` is high. With a tick every third cycle, the gate lasts three times as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Captures cfg_mode and cfg_time |
| cfg_mode | input | 2 | Measurement mode code, 2'b00 = frequency |
| cfg_time | input | 2 | Gate-time code |
| start | input | 1 | Start or restart a measurement |
| done_clr | input | 1 | Clears the completion flag |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| inhibit | input | 1 | Low-power input disable |
| sig_in | input | 1 | Asynchronous signal to be measured |
| busy | output | 1 | Gate open |
| done | output | 1 | Completion flag |
| result | output | CNT_W | Latched edge count |
| overflow | output | 1 | Latched saturation indication |

## Verification
The main path is exercised with bursts of 0 to 16 clean pulses under each of the four gate codes. Each burst shows whether the count is exact and whether the gate length follows the selected code rather than a fixed one. The same bursts are repeated with inhibit high, which separates an input that is actually masked from a count that is only reported late. Three further patterns each isolate one effect: pulses sent after the gate closes, pulses split by a restart, and a slowed reference tick. Together they show that only edges inside the current window count and that the window is measured in reference ticks, not clock cycles. A 4-bit instance receives exactly 15 pulses and then 20 pulses, which separates the saturation point from a wrapped count.

// File: rtl/freq_ctr_pkg.sv
package freq_ctr_pkg;
   typedef enum logic [1:0] {
      MODE_FREQ  = 2'b00,
      MODE_RSV_A = 2'b01,
      MODE_RSV_B = 2'b10,
      MODE_RSV_C = 2'b11
   } meas_mode_e;

   typedef enum logic [1:0] {
      GATE_SHORT = 2'b00,
      GATE_MID   = 2'b01,
      GATE_LONG  = 2'b10,
      GATE_MAX   = 2'b11
   } gate_sel_e;
endpackage

// File: rtl/freq_ctr_sync.sv
module freq_ctr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/freq_ctr_gate.sv
module freq_ctr_gate #(
   parameter int TICKS_PER_MS = 75,
   parameter int MS0 = 1,
   parameter int MS1 = 4,
   parameter int MS2 = 8,
   parameter int MS3 = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       open_o,
   output logic       close_o
);
   localparam int MAX_MS = (MS0 > MS1 ? MS0 : MS1) > (MS2 > MS3 ? MS2 : MS3)
                         ? (MS0 > MS1 ? MS0 : MS1) : (MS2 > MS3 ? MS2 : MS3);
   localparam int RW = $clog2(TICKS_PER_MS * MAX_MS + 1);
   localparam int LEN [4] = '{TICKS_PER_MS * MS0, TICKS_PER_MS * MS1,
                              TICKS_PER_MS * MS2, TICKS_PER_MS * MS3};

   logic [RW-1:0] remain;
   logic          open_q;

   assign close_o = open_q && tick && (remain == RW'(1)) && !launch;
   assign open_o  = open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         open_q <= 1'b0;
      end else if (launch) begin
         remain <= RW'(LEN[sel]);
         open_q <= 1'b1;
      end else if (open_q && tick) begin
         remain <= remain - RW'(1);
         if (remain == RW'(1)) open_q <= 1'b0;
      end
   end
endmodule

// File: rtl/freq_ctr_accum.sv
module freq_ctr_accum #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             count_en,
   input  logic             close,
   output logic [CNT_W-1:0] result,
   output logic             overflow
);
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             sat_q, sat_nxt;

   always_comb begin
      cnt_nxt = cnt_q;
      sat_nxt = sat_q;
      if (count_en) begin
         if (&cnt_q) sat_nxt = 1'b1;
         else        cnt_nxt = cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         sat_q    <= 1'b0;
         result   <= '0;
         overflow <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         sat_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         sat_q <= sat_nxt;
         if (close) begin
            result   <= cnt_nxt;
            overflow <= sat_nxt;
         end
      end
   end
endmodule

// File: rtl/freq_ctr.sv
module freq_ctr
   import freq_ctr_pkg::*;
#(
   parameter int CNT_W        = 20,
   parameter int SYNC_STAGES  = 2,
   parameter int TICKS_PER_MS = 75,
   parameter int MS0          = 1,
   parameter int MS1          = 4,
   parameter int MS2          = 8,
   parameter int MS3          = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_time,
   input  logic             start,
   input  logic             done_clr,
   input  logic             ref_tick,
   input  logic             inhibit,
   input  logic             sig_in,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] result,
   output logic             overflow
);
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("freq_ctr: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("freq_ctr: SYNC_STAGES must be at least 2");
   end
   if (TICKS_PER_MS < 1 || MS0 < 1 || MS1 < 1 || MS2 < 1 || MS3 < 1) begin : g_bad_gate
      $error("freq_ctr: gate lengths must be positive");
   end

   meas_mode_e mode_q;
   gate_sel_e  time_q;
   logic       launch, close, rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_FREQ;
         time_q <= GATE_SHORT;
      end else if (cfg_we) begin
         mode_q <= meas_mode_e'(cfg_mode);
         time_q <= gate_sel_e'(cfg_time);
      end
   end

   assign launch = start && (mode_q == MODE_FREQ);

   freq_ctr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .din (sig_in), .rise (rise)
   );

   freq_ctr_gate #(
      .TICKS_PER_MS(TICKS_PER_MS), .MS0(MS0), .MS1(MS1), .MS2(MS2), .MS3(MS3)
   ) u_gate (
      .clk (clk), .rst_n (rst_n), .launch (launch), .tick (ref_tick),
      .sel (time_q), .open_o (busy), .close_o (close)
   );

   freq_ctr_accum #(.CNT_W(CNT_W)) u_accum (
      .clk (clk), .rst_n (rst_n), .clear (launch),
      .count_en (rise && busy && !inhibit), .close (close),
      .result (result), .overflow (overflow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        done <= 1'b0;
      else if (launch)   done <= 1'b0;
      else if (close)    done <= 1'b1;
      else if (done_clr) done <= 1'b0;
   end
endmodule

// File: rtl/freq_ctr_chk.sv
module freq_ctr_chk #(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             done_clr,
   input logic [1:0]       mode_q,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] result,
   input logic             overflow
);
   a_r5_done_at_close: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && !start && !busy) |=> !done);

   a_r6_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode_q == 2'b00) |=> (busy && !done));

   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode_q != 2'b00 && !busy) |=> !busy);

   a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $fell(busy));

   a_r8_sat_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (&result));
endmodule

bind freq_ctr freq_ctr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .start (start), .done_clr (done_clr),
   .mode_q (mode_q), .busy (busy), .done (done), .result (result),
   .overflow (overflow)
);

// File: tb/freq_ctr_bench.sv
module freq_ctr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'b00;
   logic [1:0]  cfg_time = 2'b00;
   logic        start = 1'b0;
   logic        done_clr = 1'b0;
   logic        ref_tick = 1'b1;
   logic        inhibit = 1'b0;
   logic        sig_in = 1'b0;
   logic        busy, done, overflow;
   logic [19:0] result;
   logic        busy_s, done_s, ovf_s;
   logic [3:0]  res_s;
   int          cyc = 0;
   int          ref_div = 1;
   int          nchk = 0;
   int          nfail = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   freq_ctr u_freq_ctr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_time(cfg_time), .start(start), .done_clr(done_clr),
      .ref_tick(ref_tick), .inhibit(inhibit), .sig_in(sig_in),
      .busy(busy), .done(done), .result(result), .overflow(overflow)
   );

   freq_ctr #(.CNT_W(4)) u_freq_ctr_sat (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_time(cfg_time), .start(start), .done_clr(done_clr),
      .ref_tick(ref_tick), .inhibit(inhibit), .sig_in(sig_in),
      .busy(busy_s), .done(done_s), .result(res_s), .overflow(ovf_s)
   );

   initial begin
      int phase = 0;
      forever begin
         @(negedge clk);
         if (ref_div <= 1) ref_tick = 1'b1;
         else begin
            ref_tick = (phase == 0);
            phase = (phase + 1) % ref_div;
         end
      end
   end

   function automatic int gate_ticks(input logic [1:0] code);
      case (code)
         2'b00: return 75;
         2'b01: return 300;
         2'b10: return 600;
         default: return 2400;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] mode, input logic [1:0] code);
      @(negedge clk);
      cfg_mode = mode; cfg_time = code; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic kick(output int c0);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      c0 = cyc;
   endtask

   task automatic pulses(input int n);
      repeat (n) begin
         sig_in = 1'b1; @(negedge clk); @(negedge clk);
         sig_in = 1'b0; @(negedge clk); @(negedge clk);
      end
   endtask

   task automatic wait_idle(input int c0, output int dur);
      while (busy) @(negedge clk);
      dur = cyc - c0;
   endtask

   // time code, pulse count, inhibit
   localparam logic [10:0] VEC [8] = '{
      {2'b00, 8'd5,  1'b0}, {2'b01, 8'd12, 1'b0}, {2'b10, 8'd0,  1'b0},
      {2'b11, 8'd16, 1'b0}, {2'b00, 8'd16, 1'b0}, {2'b01, 8'd7,  1'b1},
      {2'b00, 8'd1,  1'b0}, {2'b11, 8'd9,  1'b1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int c0, dur, keep;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0); chk("R1 done", done, 0);
      chk("R1 result", result, 0); chk("R1 overflow", overflow, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R7 vector walk
      for (int i = 0; i < 8; i++) begin
         logic [1:0] code; int np; bit inh;
         {code, np, inh} = {VEC[i][10:9], int'(VEC[i][8:1]), VEC[i][0]};
         cfg(2'b00, code);
         inhibit = inh;
         kick(c0);
         pulses(np);
         repeat (4) @(negedge clk);
         inhibit = 1'b0;
         wait_idle(c0, dur);
         chk($sformatf("R3 vec%0d gate length", i), dur, gate_ticks(code));
         chk($sformatf("R4/R7 vec%0d count", i), result, inh ? 0 : np);
         chk($sformatf("R5 vec%0d done", i), done, 1);
         chk($sformatf("R8 vec%0d no overflow", i), overflow, 0);
      end

      // R4 edges after the gate are ignored
      keep = result;
      pulses(3);
      repeat (4) @(negedge clk);
      chk("R4 post-gate pulses", result, keep);

      // R5 clear, and close winning over a simultaneous clear
      cfg(2'b00, 2'b00);
      kick(c0);
      pulses(4);
      while (cyc - c0 < 74) @(negedge clk);
      chk("R5 still busy before last tick", busy, 1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R5 close wins over clear", done, 1);
      chk("R5 gate closed", busy, 0);
      chk("R4 count with clear race", result, 4);
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      chk("R5 done cleared", done, 0);

      // R4 result held while the next gate runs
      cfg(2'b00, 2'b01);
      kick(c0);
      pulses(9);
      chk("R4 result held mid-gate", result, 4);
      wait_idle(c0, dur);
      chk("R4 new result", result, 9);

      // R6 restart mid-gate
      cfg(2'b00, 2'b00);
      kick(c0);
      chk("R6 done cleared by start", done, 0);
      pulses(6);
      kick(c0);
      pulses(2);
      wait_idle(c0, dur);
      chk("R6 restarted gate length", dur, 75);
      chk("R6 count after restart", result, 2);

      // R2 bus changes without write enable are ignored
      cfg(2'b00, 2'b01);
      cfg_time = 2'b11; cfg_mode = 2'b10;
      kick(c0);
      wait_idle(c0, dur);
      chk("R2 latched time code", dur, 300);

      // R9 non-frequency mode ignores start
      cfg(2'b01, 2'b00);
      kick(c0);
      chk("R9 start ignored busy", busy, 0);
      chk("R9 start ignored done", done, 1);

      // R10 slowed reference tick
      cfg(2'b00, 2'b00);
      ref_div = 3;
      kick(c0);
      wait_idle(c0, dur);
      chk("R10 gate follows tick", int'(dur >= 223 && dur <= 225), 1);
      ref_div = 1;
      @(negedge clk);

      // R8 saturation on 4-bit instance
      cfg(2'b00, 2'b00);
      kick(c0);
      pulses(15);
      wait_idle(c0, dur);
      chk("R8 exact max count", res_s, 15);
      chk("R8 exact max no overflow", ovf_s, 0);
      cfg(2'b00, 2'b01);
      kick(c0);
      pulses(20);
      wait_idle(c0, dur);
      chk("R8 saturated value", res_s, 15);
      chk("R8 overflow set", ovf_s, 1);
      chk("R8 wide instance count", result, 20);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule